// File: doc/BRIEF.md
# VLIW Bundle Co-Issue Legality Checker

This block judges whether one wide instruction bundle may issue as it stands. A decoded format index and one operation class for each of up to five issue slots arrive together. The block looks up which kind of lane each slot of that format provides. It then tests every slot's class against its lane and returns a verdict: a legal flag, an error code naming the rule that broke, the index of the lowest offending slot, and the number of real (non-NOP) operations in the bundle.

Requests enter through a valid/ready input and leave through a valid/ready output that holds one result. A request is accepted on a rising clock edge when `in_valid_i` and `in_ready_o` are both high. Its verdict appears on the output from the next edge on. `in_ready_o` is high whenever the output register is empty or is being drained in the same cycle (`out_ready_i` high). While `out_valid_o` is high and `out_ready_i` is low, every output holds still and no new request is taken. No request is ever dropped or duplicated.

Top module: `bundle_issue_checker`

## Requirements
- R1: Format indices are 0, 1 and 2 (single-instruction, one slot), 3 (4-lane A), 4 (5-lane B), 5 (4-lane C), 6 (4-lane D), 7 (5-lane E), 8 (dual-load F), 9 (4-lane G), 10 (4-lane H), 11 (narrow M), 12 (narrow P) and 13 (narrow Q). Index 14 or 15 is illegal with error code 1 at slot 0.
- R2: Slot class codes are 0 NOP, 1 load, 2 scalar store, 3 vector store, 4 gather, 5 integer quad-MAC, 6 FP multiply-add and 7 ALU, with slot k at bits [3k+2:3k]. A non-NOP class in a slot at or beyond the format's slot count is illegal with code 2. The slot counts are 1 for formats 0 to 2, 5 for formats 4 and 7, 3 for format 11, 2 for format 12 and 4 for the others.
- R3: Filler slots accept only NOP, and any other class there gives code 3. The filler slots are slot 1 of format 11 and slots 1 and 2 of format 13.
- R4: Stores (classes 2 and 3) are legal only in slot 0, so a bundle holds at most one store. Slot 0 of format 8 takes scalar but not vector stores, and slot 0 of format 4 takes no store at all. A misplaced store gives code 4.
- R5: Loads and gathers are legal only in memory lanes. Memory lanes are slot 0 of every multi-slot format and slot 1 of formats 3, 5 to 10 and 12. A misplaced load or gather gives code 7.
- R6: Integer quad-MAC is legal only in the multiply lane, which is slot 2 of formats 3 to 11, so a bundle holds at most one. A misplaced quad-MAC gives code 5.
- R7: FP multiply-add is legal in the slot-3 ALU lane of every format that has one. It is also legal in the multiply lane of formats 6, 10 and 11, and nowhere else (code 6).
- R8: ALU ops are legal in slot 3, in slot 4 of formats 4 and 7, in slot 1 of format 4 and in slot 0 of format 5, and nowhere else (code 8). The one slot of formats 0 to 2 accepts any class.
- R9: A legal bundle reports code 0. An illegal one reports the code of its lowest-numbered offending slot, together with that slot's index.
- R10: The op count is the number of non-NOP slots when the bundle is legal and 0 when it is not. The maximum is 5, reached only in formats 4 and 7.
- R11: After reset the output is empty and `in_ready_o` is high. A verdict is registered one cycle after acceptance. While the output is stalled the verdict holds and `in_ready_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid_i | input | 1 | Request present |
| in_ready_o | output | 1 | Request can be taken this cycle |
| fmt_i | input | 4 | Decoded format index |
| slot_cls_i | input | 15 | Per-slot class codes, 3 bits per slot |
| out_valid_o | output | 1 | Verdict present |
| out_ready_i | input | 1 | Consumer takes the verdict |
| legal_o | output | 1 | Bundle may issue |
| err_code_o | output | 4 | Rule that failed (0 when legal) |
| err_slot_o | output | 3 | Lowest offending slot |
| op_count_o | output | 3 | Real ops issued (0 when illegal) |

## Verification
The hardest situation to reach is a bundle that breaks several rules at once in different slots, where the lowest slot's rule must win over a rule that an earlier check in the code would otherwise report. The bench builds such bundles on purpose, for example a misplaced store in slot 1 beside a misplaced quad-MAC in slot 3. It also drives the narrow formats whose filler slots and missing slots lie right next to valid lanes. Stalls are reached by holding the output unready while a second request waits at the input, so that both the held verdict and the later acceptance of the waiting request can be observed.

// File: rtl/bnd_pkg.sv
package bnd_pkg;

  localparam int CLS_W    = 3;
  localparam int FMT_W    = 4;
  localparam int CODE_W   = 4;
  localparam int ROW_LEN  = 5;   // widest roster in the format table
  localparam int NUM_FMT  = 14;

  typedef enum logic [CLS_W-1:0] {
    C_NOP    = 3'd0,
    C_LOAD   = 3'd1,
    C_SST    = 3'd2,
    C_VST    = 3'd3,
    C_GATHER = 3'd4,
    C_QMAC   = 3'd5,
    C_FMA    = 3'd6,
    C_ALU    = 3'd7
  } op_cls_e;

  // Kind of issue lane a slot offers within a format
  typedef enum logic [3:0] {
    L_ABSENT,   // slot index beyond the roster
    L_FILLER,   // NOP-only padding
    L_ANY,      // single-instruction format
    L_LDST,     // full memory lane
    L_LDSTALU,  // memory lane that also takes ALU ops
    L_LD,       // load/gather lane
    L_LDSST,    // load/gather plus scalar store
    L_MUL,      // multiply lane
    L_MULFMA,   // multiply lane that also takes FP multiply-add
    L_ALU,      // ALU lane
    L_ALUFMA    // slot-3 ALU lane, takes FP multiply-add
  } lane_e;

  typedef enum logic [CODE_W-1:0] {
    E_NONE   = 4'd0,
    E_FORMAT = 4'd1,
    E_ABSENT = 4'd2,
    E_FILLER = 4'd3,
    E_STORE  = 4'd4,
    E_QMAC   = 4'd5,
    E_FMA    = 4'd6,
    E_MEM    = 4'd7,
    E_ALU    = 4'd8
  } err_e;

  function automatic logic is_store(op_cls_e c);
    return (c == C_SST) || (c == C_VST);
  endfunction

endpackage

// File: rtl/bnd_roster.sv
module bnd_roster
  import bnd_pkg::*;
#(
  parameter int NUM_SLOTS = 5
) (
  input  logic [FMT_W-1:0] fmt_i,
  output lane_e            lanes_o [NUM_SLOTS],
  output logic             fmt_ok_o
);

  lane_e row [ROW_LEN];

  always_comb begin
    for (int k = 0; k < ROW_LEN; k++) row[k] = L_ABSENT;
    fmt_ok_o = 1'b1;
    unique case (fmt_i)
      4'd0, 4'd1, 4'd2: row[0] = L_ANY;
      4'd3, 4'd9: begin
        row[0] = L_LDST; row[1] = L_LD; row[2] = L_MUL; row[3] = L_ALUFMA;
      end
      4'd4: begin
        row[0] = L_LD;  row[1] = L_ALU; row[2] = L_MUL;
        row[3] = L_ALUFMA; row[4] = L_ALU;
      end
      4'd5: begin
        row[0] = L_LDSTALU; row[1] = L_LD; row[2] = L_MUL; row[3] = L_ALUFMA;
      end
      4'd6, 4'd10: begin
        row[0] = L_LDST; row[1] = L_LD; row[2] = L_MULFMA; row[3] = L_ALUFMA;
      end
      4'd7: begin
        row[0] = L_LDST; row[1] = L_LD; row[2] = L_MUL;
        row[3] = L_ALUFMA; row[4] = L_ALU;
      end
      4'd8: begin
        row[0] = L_LDSST; row[1] = L_LD; row[2] = L_MUL; row[3] = L_ALUFMA;
      end
      4'd11: begin
        row[0] = L_LDST; row[1] = L_FILLER; row[2] = L_MULFMA;
      end
      4'd12: begin
        row[0] = L_LDST; row[1] = L_LD;
      end
      4'd13: begin
        row[0] = L_LDST; row[1] = L_FILLER; row[2] = L_FILLER; row[3] = L_ALUFMA;
      end
      default: fmt_ok_o = 1'b0;
    endcase
  end

  for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_lane
    if (k < ROW_LEN) begin : g_real
      assign lanes_o[k] = row[k];
    end else begin : g_pad
      assign lanes_o[k] = L_ABSENT;
    end
  end

endmodule

// File: rtl/bnd_lane_check.sv
module bnd_lane_check
  import bnd_pkg::*;
(
  input  lane_e   lane_i,
  input  op_cls_e cls_i,
  output logic    ok_o,
  output err_e    cause_o
);

  logic fits;

  always_comb begin
    unique case (lane_i)
      L_ANY:     fits = 1'b1;
      L_LDST:    fits = (cls_i inside {C_LOAD, C_SST, C_VST, C_GATHER});
      L_LDSTALU: fits = (cls_i inside {C_LOAD, C_SST, C_VST, C_GATHER, C_ALU});
      L_LD:      fits = (cls_i inside {C_LOAD, C_GATHER});
      L_LDSST:   fits = (cls_i inside {C_LOAD, C_GATHER, C_SST});
      L_MUL:     fits = (cls_i == C_QMAC);
      L_MULFMA:  fits = (cls_i inside {C_QMAC, C_FMA});
      L_ALU:     fits = (cls_i == C_ALU);
      L_ALUFMA:  fits = (cls_i inside {C_ALU, C_FMA});
      default:   fits = 1'b0;
    endcase
    ok_o = fits || (cls_i == C_NOP);
  end

  always_comb begin
    if (ok_o)                      cause_o = E_NONE;
    else if (lane_i == L_ABSENT)   cause_o = E_ABSENT;
    else if (lane_i == L_FILLER)   cause_o = E_FILLER;
    else begin
      unique case (cls_i)
        C_SST, C_VST:     cause_o = E_STORE;
        C_QMAC:           cause_o = E_QMAC;
        C_FMA:            cause_o = E_FMA;
        C_LOAD, C_GATHER: cause_o = E_MEM;
        default:          cause_o = E_ALU;
      endcase
    end
  end

endmodule

// File: rtl/bnd_verdict.sv
module bnd_verdict
  import bnd_pkg::*;
#(
  parameter int NUM_SLOTS = 5,
  localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
  localparam int CNT_W  = $clog2(NUM_SLOTS + 1)
) (
  input  logic              fmt_ok_i,
  input  logic [NUM_SLOTS-1:0] ok_i,
  input  err_e              cause_i [NUM_SLOTS],
  input  logic [NUM_SLOTS-1:0] real_i,
  output logic              legal_o,
  output err_e              code_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic [CNT_W-1:0]  count_o
);

  logic [CNT_W-1:0] n_real;

  always_comb begin
    n_real = '0;
    for (int k = 0; k < NUM_SLOTS; k++) n_real = n_real + CNT_W'(real_i[k]);
  end

  always_comb begin
    code_o = E_NONE;
    slot_o = '0;
    if (!fmt_ok_i) begin
      code_o = E_FORMAT;
    end else begin
      // scan downwards so the lowest failing slot is the last one written
      for (int k = NUM_SLOTS - 1; k >= 0; k--) begin
        if (!ok_i[k]) begin
          code_o = cause_i[k];
          slot_o = SLOT_W'(k);
        end
      end
    end
    legal_o = (code_o == E_NONE);
    count_o = legal_o ? n_real : '0;
  end

endmodule

// File: rtl/bundle_issue_checker.sv
module bundle_issue_checker
  import bnd_pkg::*;
#(
  parameter int NUM_SLOTS = 5,
  localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
  localparam int CNT_W  = $clog2(NUM_SLOTS + 1),
  localparam int BUS_W  = NUM_SLOTS * CLS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [FMT_W-1:0]  fmt_i,
  input  logic [BUS_W-1:0]  slot_cls_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic              legal_o,
  output logic [CODE_W-1:0] err_code_o,
  output logic [SLOT_W-1:0] err_slot_o,
  output logic [CNT_W-1:0]  op_count_o
);

  lane_e              lanes [NUM_SLOTS];
  op_cls_e            cls   [NUM_SLOTS];
  err_e               cause [NUM_SLOTS];
  logic [NUM_SLOTS-1:0] ok, real_op, store_m, qmac_m;
  logic               fmt_ok;
  logic               v_legal;
  err_e               v_code;
  logic [SLOT_W-1:0]  v_slot;
  logic [CNT_W-1:0]   v_count;
  logic               take;

  bnd_roster #(.NUM_SLOTS(NUM_SLOTS)) u_roster (
    .fmt_i    (fmt_i),
    .lanes_o  (lanes),
    .fmt_ok_o (fmt_ok)
  );

  for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
    assign cls[k]     = op_cls_e'(slot_cls_i[k*CLS_W +: CLS_W]);
    assign real_op[k] = (cls[k] != C_NOP);
    assign store_m[k] = is_store(cls[k]);
    assign qmac_m[k]  = (cls[k] == C_QMAC);

    bnd_lane_check u_chk (
      .lane_i  (lanes[k]),
      .cls_i   (cls[k]),
      .ok_o    (ok[k]),
      .cause_o (cause[k])
    );
  end

  bnd_verdict #(.NUM_SLOTS(NUM_SLOTS)) u_verdict (
    .fmt_ok_i (fmt_ok),
    .ok_i     (ok),
    .cause_i  (cause),
    .real_i   (real_op),
    .legal_o  (v_legal),
    .code_o   (v_code),
    .slot_o   (v_slot),
    .count_o  (v_count)
  );

  // One-entry output stage
  assign in_ready_o = !out_valid_o || out_ready_i;
  assign take       = in_valid_i && in_ready_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid_o <= 1'b0;
      legal_o     <= 1'b0;
      err_code_o  <= '0;
      err_slot_o  <= '0;
      op_count_o  <= '0;
    end else begin
      if (in_ready_o) out_valid_o <= in_valid_i;
      if (take) begin
        legal_o    <= v_legal;
        err_code_o <= v_code;
        err_slot_o <= v_slot;
        op_count_o <= v_count;
      end
    end
  end

  // R1: an unknown format never passes
  p_bad_format_r1: assert property (@(posedge clk) disable iff (!rst_n)
    take && (fmt_i >= FMT_W'(NUM_FMT)) |=> !legal_o && (err_code_o == E_FORMAT));

  // R4: a bundle judged legal carries stores only in slot 0
  p_store_lane0_r4: assert property (@(posedge clk) disable iff (!rst_n)
    take && v_legal |-> ($countones(store_m) <= 1) && ((store_m >> 1) == '0));

  // R6: a bundle judged legal carries at most one quad-MAC
  p_one_qmac_r6: assert property (@(posedge clk) disable iff (!rst_n)
    take && v_legal |-> $countones(qmac_m) <= 1);

  // R9: legal flag and zero code agree on every verdict
  p_code_matches_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o |-> (legal_o == (err_code_o == '0)));

  // R10: illegal bundles count no ops; count never exceeds the slot bound
  p_count_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o |-> (op_count_o <= CNT_W'(NUM_SLOTS)) && (legal_o || op_count_o == '0));

  // R11: an accepted request yields a verdict on the next cycle
  p_accept_r11: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_valid_o);

  // R11: a stalled verdict holds
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(legal_o)
      && $stable(err_code_o) && $stable(err_slot_o) && $stable(op_count_o));

endmodule

// File: tb/test_bundle_issue_checker.sv
module test_bundle_issue_checker;

  localparam int NOP = 0, LD = 1, SST = 2, VST = 3, GTH = 4, QMAC = 5, FMA = 6, ALU = 7;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [3:0]  fmt = '0;
  logic [14:0] cls = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic        legal;
  logic [3:0]  code;
  logic [2:0]  slot;
  logic [2:0]  cnt;

  int n_tests = 0;
  int n_fail  = 0;

  always #2 clk = ~clk;  // 250 MHz

  bundle_issue_checker i_bundle_issue_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid_i  (in_valid),
    .in_ready_o  (in_ready),
    .fmt_i       (fmt),
    .slot_cls_i  (cls),
    .out_valid_o (out_valid),
    .out_ready_i (out_ready),
    .legal_o     (legal),
    .err_code_o  (code),
    .err_slot_o  (slot),
    .op_count_o  (cnt)
  );

  function automatic logic [14:0] pk(int c0, int c1, int c2, int c3, int c4);
    return {c4[2:0], c3[2:0], c2[2:0], c1[2:0], c0[2:0]};
  endfunction

  task automatic check(string req, logic ok, string what, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic expect_out(string req, int e_legal, int e_code, int e_slot, int e_cnt);
    check(req, out_valid == 1'b1, "out_valid", int'(out_valid), 1);
    check(req, {legal, code, slot, cnt} == {1'(e_legal), 4'(e_code), 3'(e_slot), 3'(e_cnt)},
          "legal/code/slot/count packed",
          int'({legal, code, slot, cnt}),
          int'({1'(e_legal), 4'(e_code), 3'(e_slot), 3'(e_cnt)}));
  endtask

  // Present one bundle, let it be taken at the next edge, check one cycle later
  task automatic judge(string req, int f, logic [14:0] c,
                       int e_legal, int e_code, int e_slot, int e_cnt);
    @(negedge clk);
    fmt = 4'(f); cls = c; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    expect_out(req, e_legal, e_code, e_slot, e_cnt);
  endtask

  task automatic t_reset_r11();
    check("R11", out_valid == 1'b0, "out_valid after reset", int'(out_valid), 0);
    check("R11", in_ready == 1'b1, "in_ready after reset", int'(in_ready), 1);
  endtask

  task automatic t_format_r1();
    judge("R1", 14, pk(ALU, NOP, NOP, NOP, NOP), 0, 1, 0, 0);
    judge("R1", 15, pk(NOP, NOP, NOP, NOP, NOP), 0, 1, 0, 0);
    judge("R1", 3, pk(VST, LD, QMAC, FMA, NOP), 1, 0, 0, 4);
    @(negedge clk);
    check("R11", out_valid == 1'b0, "out_valid drains", int'(out_valid), 0);
  endtask

  task automatic t_absent_r2();
    judge("R2", 0, pk(ALU, ALU, NOP, NOP, NOP), 0, 2, 1, 0);
    judge("R2", 12, pk(SST, LD, ALU, NOP, NOP), 0, 2, 2, 0);
    judge("R2", 9, pk(LD, LD, QMAC, ALU, ALU), 0, 2, 4, 0);
  endtask

  task automatic t_filler_r3();
    judge("R3", 13, pk(NOP, LD, NOP, NOP, NOP), 0, 3, 1, 0);
    judge("R3", 11, pk(SST, ALU, QMAC, NOP, NOP), 0, 3, 1, 0);
    judge("R3", 13, pk(SST, NOP, NOP, ALU, NOP), 1, 0, 0, 2);
  endtask

  task automatic t_store_r4();
    judge("R4", 3, pk(LD, SST, NOP, NOP, NOP), 0, 4, 1, 0);
    judge("R4", 8, pk(SST, LD, QMAC, ALU, NOP), 1, 0, 0, 4);
    judge("R4", 8, pk(VST, LD, NOP, NOP, NOP), 0, 4, 0, 0);
    judge("R4", 4, pk(SST, NOP, NOP, NOP, NOP), 0, 4, 0, 0);
    judge("R4", 6, pk(VST, GTH, FMA, ALU, NOP), 1, 0, 0, 4);
  endtask

  task automatic t_memory_r5();
    judge("R5", 3, pk(GTH, GTH, NOP, NOP, NOP), 1, 0, 0, 2);
    judge("R5", 7, pk(NOP, NOP, NOP, GTH, NOP), 0, 7, 3, 0);
    judge("R5", 4, pk(LD, LD, NOP, NOP, NOP), 0, 7, 1, 0);
    judge("R5", 12, pk(LD, GTH, NOP, NOP, NOP), 1, 0, 0, 2);
  endtask

  task automatic t_qmac_r6();
    judge("R6", 3, pk(NOP, NOP, NOP, QMAC, NOP), 0, 5, 3, 0);
    judge("R6", 12, pk(QMAC, NOP, NOP, NOP, NOP), 0, 5, 0, 0);
    judge("R6", 11, pk(NOP, NOP, QMAC, NOP, NOP), 1, 0, 0, 1);
  endtask

  task automatic t_fma_r7();
    judge("R7", 10, pk(NOP, NOP, FMA, FMA, NOP), 1, 0, 0, 2);
    judge("R7", 3, pk(NOP, NOP, FMA, NOP, NOP), 0, 6, 2, 0);
    judge("R7", 7, pk(NOP, NOP, NOP, ALU, FMA), 0, 6, 4, 0);
    judge("R7", 11, pk(LD, NOP, FMA, NOP, NOP), 1, 0, 0, 2);
    judge("R7", 4, pk(NOP, FMA, NOP, NOP, NOP), 0, 6, 1, 0);
  endtask

  task automatic t_alu_r8();
    judge("R8", 5, pk(ALU, LD, QMAC, ALU, NOP), 1, 0, 0, 4);
    judge("R8", 3, pk(NOP, ALU, NOP, NOP, NOP), 0, 8, 1, 0);
    judge("R8", 3, pk(ALU, NOP, NOP, NOP, NOP), 0, 8, 0, 0);
    judge("R8", 1, pk(QMAC, NOP, NOP, NOP, NOP), 1, 0, 0, 1);
  endtask

  task automatic t_priority_r9();
    judge("R9", 3, pk(LD, SST, NOP, QMAC, NOP), 0, 4, 1, 0);
    judge("R9", 13, pk(ALU, ALU, NOP, FMA, NOP), 0, 8, 0, 0);
  endtask

  task automatic t_count_r10();
    judge("R10", 7, pk(SST, GTH, QMAC, ALU, ALU), 1, 0, 0, 5);
    judge("R10", 4, pk(LD, ALU, QMAC, FMA, ALU), 1, 0, 0, 5);
    judge("R10", 3, pk(NOP, NOP, NOP, NOP, NOP), 1, 0, 0, 0);
  endtask

  task automatic t_stall_r11();
    @(negedge clk);
    out_ready = 1'b0;
    fmt = 4'd3; cls = pk(LD, LD, QMAC, ALU, NOP); in_valid = 1'b1;
    @(negedge clk);
    // second request waits behind the held verdict
    fmt = 4'd14; cls = pk(NOP, NOP, NOP, NOP, NOP);
    expect_out("R11", 1, 0, 0, 4);
    check("R11", in_ready == 1'b0, "in_ready while stalled", int'(in_ready), 0);
    repeat (2) @(negedge clk);
    expect_out("R11", 1, 0, 0, 4);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    expect_out("R11", 0, 1, 0, 0);
    @(negedge clk);
    check("R11", out_valid == 1'b0, "out_valid after drain", int'(out_valid), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset_r11();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_r11();
    t_format_r1();
    t_absent_r2();
    t_filler_r3();
    t_store_r4();
    t_memory_r5();
    t_qmac_r6();
    t_fma_r7();
    t_alu_r8();
    t_priority_r9();
    t_count_r10();
    t_stall_r11();
    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: run hung actual=%0d expected=%0d", n_tests, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule